// File: doc/BRIEF.md
# Flash Busy Status Read Multiplexer

This block forms the byte that a flash device returns on a read. While the internal program or erase engine is busy, the byte carries two status bits instead of array contents. The top bit is a polling bit that depends on the running operation. The bit below it flips on each successive read. When the engine is idle, the byte read from the array passes through unchanged.

Each read is marked by a one-cycle strobe. The result is registered on the clock edge where the strobe is high and held until the next strobe. The engine supplies a busy flag, an operation-type flag and the last byte loaded for programming. The block neither starts operations nor decodes addresses.

Top module: `flash_busy_status_mux`

## Requirements
- R1: After reset, `rdData` is all zeros and the internal toggle state is 0.
- R2: `rdData` changes only in the cycle after a clock edge where `rdStrobe` is 1. That edge takes the inputs present at it. In all other cycles `rdData` keeps its value.
- R3: A read taken while `busy` is 0 returns `arrayData` unaltered in all bits.
- R4: A read taken while `busy` is 1 and `opErase` is 0 (program) returns bit 7 equal to the complement of `lastByte` bit 7.
- R5: A read taken while `busy` is 1 and `opErase` is 1 (block or chip erase) returns bit 7 equal to 0.
- R6: Bit 6 of successive reads taken while `busy` is 1 alternates, however many cycles lie between the reads. The first such read after reset returns 0.
- R7: The toggle state advances only on a read strobe while `busy` is 1. Cycles without a strobe and reads while idle leave it unchanged, so the next busy read continues the sequence.
- R8: Bits 5 down to 0 of every read taken while `busy` is 1 are 0.
- R9: The first read after `busy` falls returns `arrayData` with no status overlay, including bits 7 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Program or erase operation in progress |
| opErase | input | 1 | 1 = erase running, 0 = program running |
| lastByte | input | 8 | Last byte loaded for programming |
| rdStrobe | input | 1 | One-cycle read request |
| arrayData | input | 8 | Byte read from the array |
| rdData | output | 8 | Byte returned to the host |

## Verification
Every result is due exactly one cycle after the edge that carries its read strobe. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares `rdData` on the next falling edge against a model updated for that edge. The model checks every cycle, not only after strobes, so a value that changes without a strobe is caught as an R2 error. The toggle sequence is tracked across idle gaps and strobe-free stretches to expose advances taken at the wrong moment.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef struct packed {
    logic capture;
    logic overlay;
    logic pollBit;
    logic toggleBit;
  } statusCtrlT;

endpackage

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              opErase,
  input  logic [DATA_W-1:0] lastByte,
  input  logic              rdStrobe,
  output statusCtrlT        ctrlOut
);

  localparam int POLL_BIT = DATA_W - 1;
  localparam logic [DATA_W-1:0] POLL_MASK = DATA_W'(1) << POLL_BIT;

  logic toggleQ;
  logic busyRead;

  assign busyRead = busy & rdStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) toggleQ <= 1'b0;
    else if (busyRead) toggleQ <= ~toggleQ;
  end

  always_comb begin
    ctrlOut.capture   = rdStrobe;
    ctrlOut.overlay   = busy;
    ctrlOut.pollBit   = ~opErase & (|(~lastByte & POLL_MASK));
    ctrlOut.toggleBit = toggleQ;
  end

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    busyRead |=> (toggleQ != $past(toggleQ))); // R6

  AST_TOGGLE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !busyRead |=> $stable(toggleQ)); // R7

endmodule

// File: rtl/flash_status_dp.sv
module flash_status_dp
  import flash_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  statusCtrlT        ctrlIn,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);

  localparam int POLL_BIT   = DATA_W - 1;
  localparam int TOGGLE_BIT = DATA_W - 2;

  logic [DATA_W-1:0] statusByte;
  logic [DATA_W-1:0] nextByte;

  for (genvar i = 0; i < DATA_W; i++) begin : g_status
    if (i == POLL_BIT) begin : g_poll
      assign statusByte[i] = ctrlIn.pollBit;
    end else if (i == TOGGLE_BIT) begin : g_tog
      assign statusByte[i] = ctrlIn.toggleBit;
    end else begin : g_zero
      assign statusByte[i] = 1'b0;
    end
  end

  assign nextByte = ctrlIn.overlay ? statusByte : arrayData;

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (ctrlIn.capture) rdData <= nextByte;
  end

  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlIn.capture |=> $stable(rdData)); // R2

endmodule

// File: rtl/flash_busy_status_mux.sv
module flash_busy_status_mux
  import flash_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              opErase,
  input  logic [DATA_W-1:0] lastByte,
  input  logic              rdStrobe,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);

  localparam int POLL_BIT   = DATA_W - 1;
  localparam int TOGGLE_BIT = DATA_W - 2;

  statusCtrlT ctrlBus;

  flash_status_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busy     (busy),
    .opErase  (opErase),
    .lastByte (lastByte),
    .rdStrobe (rdStrobe),
    .ctrlOut  (ctrlBus)
  );

  flash_status_dp #(.DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlIn    (ctrlBus),
    .arrayData (arrayData),
    .rdData    (rdData)
  );

  initial begin
    AST_WIDTH_OK: assert (DATA_W >= 3);
  end

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !busy) |=> (rdData == $past(arrayData))); // R3

  AST_PGM_POLL: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && busy && !opErase) |=> (rdData[POLL_BIT] == ~$past(lastByte[POLL_BIT]))); // R4

  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && busy && opErase) |=> (rdData[POLL_BIT] == 1'b0)); // R5

  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && busy) |=> (rdData[TOGGLE_BIT-1:0] == '0)); // R8

endmodule

// File: tb/test_flash_busy_status_mux.sv
module test_flash_busy_status_mux;

  logic       clk = 1'b0;
  logic       rstN;
  logic       busy, opErase, rdStrobe;
  logic [7:0] lastByte, arrayData;
  logic [7:0] rdData;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] expData;
  logic       expTog;
  logic       wasBusy;

  always #2.5 clk = ~clk;

  flash_busy_status_mux #(.DATA_W(8)) i_flash_busy_status_mux (
    .clk(clk), .rstN(rstN), .busy(busy), .opErase(opErase),
    .lastByte(lastByte), .rdStrobe(rdStrobe),
    .arrayData(arrayData), .rdData(rdData)
  );

  function automatic logic [7:0] busyByte(input logic er, input logic [7:0] lb,
                                          input logic tg);
    busyByte = {(er ? 1'b0 : ~lb[7]), tg, 6'b0};
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    total++;
    if (rdData !== exp) begin
      bad++;
      $display("FAIL %s: rdData=%h expected=%h", req, rdData, exp);
    end
  endtask

  // drive on negedge, one posedge, check on next negedge
  task automatic step(input logic b, input logic er, input logic [7:0] lb,
                      input logic [7:0] ar, input logic st);
    string req;
    busy = b; opErase = er; lastByte = lb; arrayData = ar; rdStrobe = st;
    @(posedge clk);
    if (!st) req = "R2";
    else if (!b) req = wasBusy ? "R9" : "R3";
    else if (er) req = "R5/R6/R8";
    else req = "R4/R6/R8";
    if (st) begin
      if (b) begin
        expData = busyByte(er, lb, expTog);
        expTog = ~expTog;
      end else begin
        expData = ar;
      end
      wasBusy = b;
    end
    @(negedge clk);
    check(req, expData);
  endtask

  initial begin
    rstN = 1'b0; busy = 0; opErase = 0; rdStrobe = 0;
    lastByte = 8'h00; arrayData = 8'hA5;
    expData = 8'h00; expTog = 1'b0; wasBusy = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 8'h00);

    // idle passthrough
    step(0, 0, 8'h00, 8'h3C, 1);
    step(0, 0, 8'h00, 8'hFF, 0);
    // program poll: first busy read toggle 0
    step(1, 0, 8'h80, 8'hFF, 1);   // R4 expect 8'h00, R6 first read 0
    step(1, 0, 8'h80, 8'hFF, 1);   // R6 toggle 1 -> 8'h40
    step(1, 0, 8'h80, 8'hFF, 0);   // R7 no advance
    step(1, 0, 8'h80, 8'hFF, 0);
    step(1, 0, 8'h7F, 8'hFF, 1);   // R4 bit7=1, toggle 0 -> 8'h80
    // busy drops: R9 returns array with no overlay
    step(0, 0, 8'h7F, 8'h12, 1);
    step(0, 0, 8'h7F, 8'hC3, 1);   // R7 idle read, no advance
    // erase
    step(1, 1, 8'h00, 8'hFF, 1);   // R5 bit7=0, toggle 1 -> 8'h40
    step(1, 1, 8'h00, 8'hFF, 1);   // 8'h00
    step(0, 1, 8'h00, 8'hFF, 1);   // R9 erased reads FF

    // constrained random
    begin
      int seed;
      logic rb, re;
      seed = 32'h1234;
      void'($urandom(seed));
      rb = 0; re = 0;
      for (int n = 0; n < 4000; n++) begin
        if ($urandom_range(0, 15) == 0) rb = ~rb;
        if (!rb && $urandom_range(0, 3) == 0) re = $urandom_range(0, 1);
        step(rb, re, 8'($urandom), 8'($urandom), $urandom_range(0, 2) != 0);
      end
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule